// File: doc/BRIEF.md
# Nibble-Bus Flash Read Host

This block is the initiating side of a 4-bit multiplexed firmware-memory bus. A client issues a single-byte read through a valid/ready request port. The request carries an address and the ID of the target device. The block then runs the whole bus transaction. It marks the start of the frame with a strobe and sends a fixed sequence of nibbles: a start code, the target ID, the address and a size code. It then gives the bus to the target through a two-cycle turnaround.

After the turnaround, the block samples one sync nibble per clock. It keeps waiting for as long as the target reports that it is not ready, up to a limit set by a parameter. When the target reports ready, the block captures the two data nibbles. It then lets the target run its own turnaround and drives the bus again. The result goes to a response port as a one-cycle pulse, with flags for an unknown sync code and for a timeout. Only one transaction is in flight at a time.

Top module: `nbus_read_host`

## Requirements
- R1: When idle (including right after reset), the block drives the bus with 1111b, holds the frame strobe high and holds req_ready high.
- R2: In the cycle after a request is accepted (req_valid and req_ready high at a clock edge), the frame strobe is low for exactly that one cycle while the bus carries the start code 1101b.
- R3: The next nine cycles carry, in order: the target ID, then the address nibbles most significant first (seven for the default 28-bit address), then the size code 0000b. The strobe stays high throughout.
- R4: After the size code the block drives 1111b for one cycle, and in the following cycle it releases the bus (bus_oe low).
- R5: From the cycle after the release, the block samples one sync nibble on bus_in per cycle. The value 0101b means wait, and the block samples again in the next cycle.
- R6: A sync of 0000b means ready. The next two cycles deliver the low data nibble and then the high nibble, and rsp_data is {high, low}.
- R7: After the data, the bus stays released for two turnaround cycles. In the next cycle the block drives 1111b again and rsp_valid is high for exactly one cycle.
- R8: If WAIT_LIMIT wait syncs arrive in a row with no ready sync (default 32), the transaction ends through the same two release cycles, with rsp_tmo set alongside rsp_valid. With WAIT_LIMIT-1 waits followed by a ready sync, the read completes normally.
- R9: Any sync value other than 0101b or 0000b ends the transaction through the two release cycles, with rsp_err set alongside rsp_valid. rsp_err and rsp_tmo are low on a successful read and are never high without rsp_valid.
- R10: req_ready stays low from the acceptance cycle until the last turnaround cycle has finished. A request held during that time is ignored and changes nothing on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W (28) | Byte address to read |
| req_id | input | ID_W (4) | Target device ID |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 8 | Byte read |
| rsp_err | output | 1 | Unknown sync code received |
| rsp_tmo | output | 1 | Wait-sync limit reached |
| bus_frame_n | output | 1 | Frame strobe, low in the start cycle |
| bus_oe | output | 1 | Host drives the nibble bus when high |
| bus_out | output | 4 | Nibble driven by the host |
| bus_in | input | 4 | Nibble sampled from the bus |

## Verification
The hardest cases to reach are at the edge of the wait-sync limit. Exactly WAIT_LIMIT-1 waits followed by a ready sync must still return data, while WAIT_LIMIT waits must end in a timeout. The bench target model therefore holds the bus at 0101b for an exact, counted number of cycles on each side of the limit. The bench also drives an unknown sync code both right after the release and after several waits. While a transaction is in progress, it holds req_valid high with a different address, which shows that the request is ignored by comparing every bus nibble against the model.

// File: rtl/nbus_pkg.sv
package nbus_pkg;

   localparam int NIB_W = 4;

   typedef logic [NIB_W-1:0] nib_t;

   localparam nib_t CODE_MEM_RD = 4'b1101;
   localparam nib_t CODE_ONE_B  = 4'b0000;
   localparam nib_t CODE_ONES   = 4'b1111;
   localparam nib_t SYNC_WAIT   = 4'b0101;
   localparam nib_t SYNC_READY  = 4'b0000;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_START,
      PH_ID,
      PH_ADDR,
      PH_SIZE,
      PH_HTAR_ONES,
      PH_HTAR_FLOAT,
      PH_SYNC,
      PH_DATA_LO,
      PH_DATA_HI,
      PH_TTAR_ONES,
      PH_TTAR_FLOAT
   } phase_t;

   typedef enum logic [1:0] {
      SK_WAIT,
      SK_READY,
      SK_OTHER
   } sync_kind_t;

endpackage

// File: rtl/nbus_addr_serial.sv
module nbus_addr_serial #(
   parameter int ADDR_W = 28,
   parameter int NIB_W  = 4,
   parameter int NIBS   = ADDR_W / NIB_W,
   parameter int IDX_W  = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [IDX_W-1:0]  idx,
   output logic [NIB_W-1:0]  nib
);

   logic [NIB_W-1:0] lane [NIBS];

   for (genvar g = 0; g < NIBS; g++) begin : g_lane
      assign lane[g] = addr[ADDR_W-1-g*NIB_W -: NIB_W];
   end

   always_comb begin
      nib = '0;
      for (int k = 0; k < NIBS; k++) begin
         if (idx == IDX_W'(k)) nib = lane[k];
      end
   end

endmodule

// File: rtl/nbus_sync_mon.sv
module nbus_sync_mon
   import nbus_pkg::*;
#(
   parameter int WAIT_LIMIT = 32,
   parameter int CW         = $clog2(WAIT_LIMIT + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  nib_t       bus_in,
   output sync_kind_t kind,
   output logic       limit_hit
);

   always_comb begin
      unique case (bus_in)
         SYNC_WAIT:  kind = SK_WAIT;
         SYNC_READY: kind = SK_READY;
         default:    kind = SK_OTHER;
      endcase
   end

   if (WAIT_LIMIT == 1) begin : g_no_count
      assign limit_hit = active && (kind == SK_WAIT);
   end else begin : g_count
      logic [CW-1:0] waits_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            waits_q <= '0;
         else if (!active)
            waits_q <= '0;
         else if (kind == SK_WAIT)
            waits_q <= waits_q + 1'b1;
      end

      assign limit_hit = active && (kind == SK_WAIT) &&
                         (waits_q == CW'(WAIT_LIMIT - 1));
   end

endmodule

// File: rtl/nbus_rx_cap.sv
module nbus_rx_cap #(
   parameter int NIB_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_lo,
   input  logic               cap_hi,
   input  logic [NIB_W-1:0]   bus_in,
   output logic [2*NIB_W-1:0] data
);

   logic [NIB_W-1:0] lo_q, hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (cap_lo) lo_q <= bus_in;
         if (cap_hi) hi_q <= bus_in;
      end
   end

   assign data = {hi_q, lo_q};

endmodule

// File: rtl/nbus_read_host.sv
module nbus_read_host
   import nbus_pkg::*;
#(
   parameter int ADDR_W     = 28,
   parameter int ID_W       = 4,
   parameter int WAIT_LIMIT = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ID_W-1:0]   req_id,
   output logic              rsp_valid,
   output logic [7:0]        rsp_data,
   output logic              rsp_err,
   output logic              rsp_tmo,
   output logic              bus_frame_n,
   output logic              bus_oe,
   output logic [3:0]        bus_out,
   input  logic [3:0]        bus_in
);

   localparam int NIBS  = ADDR_W / NIB_W;
   localparam int IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NIBS - 1);

   if (ID_W != NIB_W) begin : g_bad_id
      $error("nbus_read_host: ID_W must equal the nibble width");
   end
   if (ADDR_W % NIB_W != 0 || NIBS < 1) begin : g_bad_addr
      $error("nbus_read_host: ADDR_W must be a positive multiple of the nibble width");
   end
   if (WAIT_LIMIT < 1) begin : g_bad_limit
      $error("nbus_read_host: WAIT_LIMIT must be at least 1");
   end

   phase_t            ph_q, ph_d;
   logic [ADDR_W-1:0] addr_q;
   nib_t              id_q;
   logic [IDX_W-1:0]  idx_q;
   logic              err_pend_q, tmo_pend_q;
   logic              rsp_valid_q, rsp_err_q, rsp_tmo_q;
   nib_t              addr_nib;
   sync_kind_t        sync_kind;
   logic              wait_limit_hit;
   logic              accept;

   assign accept = req_valid && (ph_q == PH_IDLE);

   nbus_addr_serial #(
      .ADDR_W (ADDR_W),
      .NIB_W  (NIB_W),
      .NIBS   (NIBS),
      .IDX_W  (IDX_W)
   ) u_addr (
      .addr (addr_q),
      .idx  (idx_q),
      .nib  (addr_nib)
   );

   nbus_sync_mon #(
      .WAIT_LIMIT (WAIT_LIMIT)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (ph_q == PH_SYNC),
      .bus_in    (bus_in),
      .kind      (sync_kind),
      .limit_hit (wait_limit_hit)
   );

   nbus_rx_cap #(
      .NIB_W (NIB_W)
   ) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_lo (ph_q == PH_DATA_LO),
      .cap_hi (ph_q == PH_DATA_HI),
      .bus_in (bus_in),
      .data   (rsp_data)
   );

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE:       if (accept) ph_d = PH_START;
         PH_START:      ph_d = PH_ID;
         PH_ID:         ph_d = PH_ADDR;
         PH_ADDR:       if (idx_q == IDX_LAST) ph_d = PH_SIZE;
         PH_SIZE:       ph_d = PH_HTAR_ONES;
         PH_HTAR_ONES:  ph_d = PH_HTAR_FLOAT;
         PH_HTAR_FLOAT: ph_d = PH_SYNC;
         PH_SYNC: begin
            if (sync_kind == SK_READY)      ph_d = PH_DATA_LO;
            else if (sync_kind == SK_OTHER) ph_d = PH_TTAR_ONES;
            else if (wait_limit_hit)        ph_d = PH_TTAR_ONES;
         end
         PH_DATA_LO:    ph_d = PH_DATA_HI;
         PH_DATA_HI:    ph_d = PH_TTAR_ONES;
         PH_TTAR_ONES:  ph_d = PH_TTAR_FLOAT;
         PH_TTAR_FLOAT: ph_d = PH_IDLE;
         default:       ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= PH_IDLE;
         addr_q     <= '0;
         id_q       <= '0;
         idx_q      <= '0;
         err_pend_q <= 1'b0;
         tmo_pend_q <= 1'b0;
      end else begin
         ph_q <= ph_d;
         if (accept) begin
            addr_q     <= req_addr;
            id_q       <= nib_t'(req_id);
            err_pend_q <= 1'b0;
            tmo_pend_q <= 1'b0;
         end
         if (ph_q == PH_START)
            idx_q <= '0;
         else if (ph_q == PH_ADDR)
            idx_q <= idx_q + 1'b1;
         if (ph_q == PH_SYNC) begin
            if (sync_kind == SK_OTHER) err_pend_q <= 1'b1;
            if (wait_limit_hit)        tmo_pend_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         rsp_tmo_q   <= 1'b0;
      end else begin
         rsp_valid_q <= (ph_q == PH_TTAR_FLOAT);
         rsp_err_q   <= (ph_q == PH_TTAR_FLOAT) && err_pend_q;
         rsp_tmo_q   <= (ph_q == PH_TTAR_FLOAT) && tmo_pend_q;
      end
   end

   always_comb begin
      bus_out = CODE_ONES;
      unique case (ph_q)
         PH_START: bus_out = CODE_MEM_RD;
         PH_ID:    bus_out = id_q;
         PH_ADDR:  bus_out = addr_nib;
         PH_SIZE:  bus_out = CODE_ONE_B;
         default:  bus_out = CODE_ONES;
      endcase
   end

   assign bus_oe      = (ph_q == PH_IDLE)  || (ph_q == PH_START) ||
                        (ph_q == PH_ID)    || (ph_q == PH_ADDR)  ||
                        (ph_q == PH_SIZE)  || (ph_q == PH_HTAR_ONES);
   assign bus_frame_n = (ph_q != PH_START);
   assign req_ready   = (ph_q == PH_IDLE);
   assign rsp_valid   = rsp_valid_q;
   assign rsp_err     = rsp_err_q;
   assign rsp_tmo     = rsp_tmo_q;

endmodule

// File: rtl/nbus_read_host_chk.sv
module nbus_read_host_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       rsp_valid,
   input logic       rsp_err,
   input logic       rsp_tmo,
   input logic       bus_frame_n,
   input logic       bus_oe,
   input logic [3:0] bus_out
);

   assert_idle_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_oe && bus_frame_n && bus_out == 4'b1111));

   assert_frame_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_frame_n |-> (bus_oe && bus_out == 4'b1101));

   assert_frame_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_frame_n |=> bus_frame_n);

   assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !bus_frame_n);

   assert_release_after_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_oe) |-> ($past(bus_out) == 4'b1111));

   assert_resp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_resp_at_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (req_ready && bus_oe));

   assert_flags_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_err || rsp_tmo) |-> rsp_valid);

   assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_err && rsp_tmo));

   assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

bind nbus_read_host nbus_read_host_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rsp_valid   (rsp_valid),
   .rsp_err     (rsp_err),
   .rsp_tmo     (rsp_tmo),
   .bus_frame_n (bus_frame_n),
   .bus_oe      (bus_oe),
   .bus_out     (bus_out)
);

// File: tb/nbus_read_host_test.sv
`timescale 1ns/1ps
module nbus_read_host_test;

   localparam int LIMIT = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [27:0] req_addr = '0;
   logic [3:0]  req_id = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_data;
   logic        rsp_err;
   logic        rsp_tmo;
   logic        bus_frame_n;
   logic        bus_oe;
   logic [3:0]  bus_out;
   logic [3:0]  bus_in = 4'hF;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   nbus_read_host #(.ADDR_W(28), .ID_W(4), .WAIT_LIMIT(LIMIT)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_id(req_id), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_tmo(rsp_tmo),
      .bus_frame_n(bus_frame_n), .bus_oe(bus_oe), .bus_out(bus_out),
      .bus_in(bus_in)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk({tag, " oe"},    32'(bus_oe), 1);
      chk({tag, " frame"}, 32'(bus_frame_n), 1);
      chk({tag, " out"},   32'(bus_out), 32'hF);
      chk({tag, " ready"}, 32'(req_ready), 1);
   endtask

   // One read; the bench plays the target and predicts every cycle.
   task automatic run_txn(input logic [27:0] a, input logic [3:0] id,
                          input int nwait, input logic [3:0] fin,
                          input logic [7:0] d, input bit poke);
      logic [3:0] exp_q[$];
      bit tmo, bad;
      int nw;
      tmo = (nwait >= LIMIT);
      bad = !tmo && (fin != 4'b0000) && (fin != 4'b0101);
      nw  = tmo ? LIMIT : nwait;

      @(negedge clk);
      chk_idle("R1 idle before request");
      chk("R7 pulse ended", 32'(rsp_valid), 0);
      req_valid = 1'b1; req_addr = a; req_id = id; bus_in = 4'hF;

      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 frame low", 32'(bus_frame_n), 0);
      chk("R2 start code", 32'(bus_out), 32'hD);
      chk("R2 oe", 32'(bus_oe), 1);
      chk("R10 ready low", 32'(req_ready), 0);

      exp_q.push_back(id);
      for (int i = 6; i >= 0; i--) exp_q.push_back(a[i*4 +: 4]);
      exp_q.push_back(4'b0000);
      foreach (exp_q[i]) begin
         @(negedge clk);
         if (poke && i == 0) begin
            req_valid = 1'b1; req_addr = ~a; req_id = ~id;
         end
         chk("R3 frame high", 32'(bus_frame_n), 1);
         chk("R3 oe", 32'(bus_oe), 1);
         chk("R3 nibble", 32'(bus_out), 32'(exp_q[i]));
         chk("R10 ready low", 32'(req_ready), 0);
      end

      @(negedge clk);
      chk("R4 ones", 32'(bus_out), 32'hF);
      chk("R4 ones oe", 32'(bus_oe), 1);
      @(negedge clk);
      chk("R4 released", 32'(bus_oe), 0);
      bus_in = 4'hF;

      for (int i = 0; i < nw; i++) begin
         @(negedge clk);
         chk("R5 released while waiting", 32'(bus_oe), 0);
         chk("R10 ready low", 32'(req_ready), 0);
         chk("R5 no response", 32'(rsp_valid), 0);
         bus_in = 4'b0101;
      end
      if (!tmo) begin
         @(negedge clk);
         chk("R5 released at sync", 32'(bus_oe), 0);
         bus_in = fin;
         if (!bad) begin
            @(negedge clk);
            chk("R6 released lo", 32'(bus_oe), 0);
            bus_in = d[3:0];
            @(negedge clk);
            chk("R6 released hi", 32'(bus_oe), 0);
            bus_in = d[7:4];
         end
      end
      @(negedge clk);
      chk("R7 target ones released", 32'(bus_oe), 0);
      chk("R10 ready low", 32'(req_ready), 0);
      bus_in = 4'hF;
      @(negedge clk);
      chk("R7 float released", 32'(bus_oe), 0);
      chk("R10 ready low last tar", 32'(req_ready), 0);
      chk("R7 no early response", 32'(rsp_valid), 0);
      if (poke) req_valid = 1'b0;

      @(negedge clk);
      chk_idle("R7 host drives again");
      chk("R7 rsp_valid", 32'(rsp_valid), 1);
      chk("R8 rsp_tmo", 32'(rsp_tmo), 32'(tmo));
      chk("R9 rsp_err", 32'(rsp_err), 32'(bad));
      if (!tmo && !bad) chk("R6 rsp_data", 32'(rsp_data), 32'(d));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_idle("R1 in reset");
      chk("R7 no rsp in reset", 32'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1 after reset");

      run_txn(28'h1234567, 4'h3, 0,  4'b0000, 8'hA5, 0);
      run_txn(28'hFEDCBA9, 4'hC, 2,  4'b0000, 8'h3C, 1);
      run_txn(28'h0000001, 4'h0, LIMIT-1, 4'b0000, 8'h81, 0);
      run_txn(28'h8000000, 4'hF, LIMIT, 4'b0000, 8'h00, 0);
      run_txn(28'h5A5A5A5, 4'h7, 0,  4'b1010, 8'h00, 0);
      run_txn(28'hA5A5A5A, 4'h9, 3,  4'b0110, 8'h00, 1);
      run_txn(28'h0F0F0F0, 4'h1, 5,  4'b0000, 8'hF0, 0);

      @(negedge clk);
      chk("R7 final pulse cleared", 32'(rsp_valid), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule